// File: doc/BRIEF.md
# General-Purpose I/O Controller with Edge-Event Interrupts

This block is a 32-pin general-purpose I/O controller that sits on a simple register bus. Software can set each pin as an input or an output. An output pin drives either push-pull or open-drain, and its level comes from an output latch written through the data register. An input pin is brought into the clock domain by a two-flop synchronizer, so software reads its level two cycles after it settles.

Every pin can also raise an interrupt. An edge detector compares each synchronized sample with the one before it. A per-pin sense bit chooses whether both edges count or only falling edges. Each counted edge sets a sticky event bit, and software clears that bit by writing a one to it. The event bits are ANDed with a per-pin enable mask, and any surviving bit raises the single interrupt line. Pin n lives in register bit 31−n in every register. The pin ports themselves are indexed by pin number.

Top module: `gpio_edge_top`

## Requirements
- R1: After reset, every register reads zero, every output enable is low, and the interrupt is low.
- R2: Registers sit at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 interrupt enable, and 0x14 edge sense. A write to direction, open-drain, enable or edge sense reads back unchanged. Any other offset, and any offset whose low two bits are nonzero, reads zero and ignores writes.
- R3: Pin n (port bit n of the pin buses) corresponds to bit 31−n of every register.
- R4: Reading the data register returns the output latch for pins whose direction bit is 1. For pins whose direction bit is 0, it returns the input level, which is visible after the second rising clock edge following a pin change.
- R5: Direction 0 means the output enable is low. Direction 1 with open-drain 0 drives the latch value with the enable high. Direction 1 with open-drain 1 drives low with the enable high when the latch is 0, and drops the enable when the latch is 1. The pin output bit is the latch bit, forced to 0 where open-drain is set.
- R6: With edge sense 0, a rising or a falling input change sets the pin's event bit on the third rising clock edge after the change. Nothing else sets an event bit.
- R7: With edge sense 1, only a falling change sets the event bit. A rising change leaves it clear.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: When an edge is detected in the same cycle as a clearing write to that bit, the bit ends up set.
- R10: The interrupt output is high exactly when some bit is set in both the event and enable registers. It follows those registers with no added clock delay.
- R11: Events are latched while their enable bit is 0. Setting the enable bit later raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| pinIn | input | 32 | Pin levels, bit n is pin n |
| pinOut | output | 32 | Pin drive values, bit n is pin n |
| pinOe | output | 32 | Pin output enables, bit n is pin n |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives isolated rising and falling changes on single pins under both sense settings. This separates both-edge sensing from falling-only sensing, and it exposes a wrong event latency against the model's three-edge pipeline. Output drive is tried under the direction, open-drain and latch combinations, with one pin in each, so a bit-order reversal or a swapped enable term shows up on a named pin. A fall is timed to land on the same edge as its clear write, which tells event priority apart from clear priority. An event latched while masked shows that masking gates only the interrupt and not the latching.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_ODR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_EDG  = 3'd5,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrOdr;
    logic    wrDat;
    logic    wrEvt;
    logic    wrMsk;
    logic    wrEdg;
    regSel_e rdSel;
  } regStrb_s;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrb_s          strb
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  regSel_e           sel;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        WORD_W'(0): sel = SEL_DIR;
        WORD_W'(1): sel = SEL_ODR;
        WORD_W'(2): sel = SEL_DAT;
        WORD_W'(3): sel = SEL_EVT;
        WORD_W'(4): sel = SEL_MSK;
        WORD_W'(5): sel = SEL_EDG;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.rdSel = sel;
    strb.wrDir = busWe && (sel == SEL_DIR);
    strb.wrOdr = busWe && (sel == SEL_ODR);
    strb.wrDat = busWe && (sel == SEL_DAT);
    strb.wrEvt = busWe && (sel == SEL_EVT);
    strb.wrMsk = busWe && (sel == SEL_MSK);
    strb.wrEdg = busWe && (sel == SEL_EDG);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrOdr, strb.wrDat, strb.wrEvt, strb.wrMsk, strb.wrEdg})); // R2

  AST_WRITE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> !(strb.wrDir || strb.wrOdr || strb.wrDat || strb.wrEvt || strb.wrMsk || strb.wrEdg)); // R2

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrb_s         strb,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irq
);

  localparam int LAST_STG = SYNC_STAGES - 1;

  // Registers held in register-bit order (bit NPINS-1-n is pin n)
  logic [NPINS-1:0] dirReg, odrReg, datReg, evtReg, mskReg, edgReg;
  logic [NPINS-1:0] pinBits, outBits, oeBits;
  logic [NPINS-1:0] syncStg [SYNC_STAGES];
  logic [NPINS-1:0] prevLvl, lvl;
  logic [NPINS-1:0] riseHit, fallHit, edgeHit, clrMask, evtNext, datView;

  // Pin numbering: pin n maps to register bit NPINS-1-n
  for (genvar n = 0; n < NPINS; n++) begin : g_pinMap
    assign pinBits[NPINS-1-n] = pinIn[n];
    assign pinOut[n]          = outBits[NPINS-1-n];
    assign pinOe[n]           = oeBits[NPINS-1-n];
  end

  // Input synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStg[i] <= '0;
      prevLvl <= '0;
    end else begin
      syncStg[0] <= pinBits;
      for (int i = 1; i < SYNC_STAGES; i++) syncStg[i] <= syncStg[i-1];
      prevLvl <= syncStg[LAST_STG];
    end
  end

  assign lvl     = syncStg[LAST_STG];
  assign riseHit = lvl & ~prevLvl;
  assign fallHit = ~lvl & prevLvl;
  assign edgeHit = fallHit | (riseHit & ~edgReg);
  assign clrMask = strb.wrEvt ? wdata : '0;
  assign evtNext = (evtReg & ~clrMask) | edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
      odrReg <= '0;
      datReg <= '0;
      evtReg <= '0;
      mskReg <= '0;
      edgReg <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wdata;
      if (strb.wrOdr) odrReg <= wdata;
      if (strb.wrDat) datReg <= wdata;
      if (strb.wrMsk) mskReg <= wdata;
      if (strb.wrEdg) edgReg <= wdata;
      evtReg <= evtNext;
    end
  end

  // Drive: open-drain pins only ever pull low
  assign outBits = datReg & ~odrReg;
  assign oeBits  = dirReg & ~(odrReg & datReg);
  assign irq     = |(evtReg & mskReg);
  assign datView = (lvl & ~dirReg) | (datReg & dirReg);

  always_comb begin
    case (strb.rdSel)
      SEL_DIR: rdata = dirReg;
      SEL_ODR: rdata = odrReg;
      SEL_DAT: rdata = datView;
      SEL_EVT: rdata = evtReg;
      SEL_MSK: rdata = mskReg;
      SEL_EDG: rdata = edgReg;
      default: rdata = '0;
    endcase
  end

  AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEvt |=> ((evtReg & $past(wdata & ~edgeHit)) == '0)); // R8

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEvt && |(edgeHit & wdata)) |=>
      ((evtReg & $past(edgeHit & wdata)) == $past(edgeHit & wdata))); // R9

  AST_NO_SPURIOUS_EVT: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((evtReg & ~$past(evtReg) & ~$past(edgeHit)) == '0)); // R6

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((evtReg & ~$past(evtReg) & $past(edgReg) & ~$past(fallHit)) == '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (mskReg == '0) |-> !irq); // R10

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & pinOut & {<<{odrReg}}) == '0)); // R5

endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irq
);

  regStrb_s strb;

  gpio_edge_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_edge_dp #(
    .NPINS       (NPINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );

endmodule

// File: tb/tb_gpio_edge_top.sv
`timescale 1ns/1ps
module tb_gpio_edge_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_top dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // Reference model, every vector indexed by pin number
  logic [31:0] mDir, mOdr, mDat, mEvt, mMsk, mEdg;
  logic [31:0] pinQ [$];

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] expRd(input logic [4:0] a);
    logic [31:0] lvl;
    lvl = pinQ[1];
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return rev(mDir);
      3'd1: return rev(mOdr);
      3'd2: return rev((mDir & mDat) | (~mDir & lvl));
      3'd3: return rev(mEvt);
      3'd4: return rev(mMsk);
      3'd5: return rev(mEdg);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = 0; mOdr = 0; mDat = 0; mEvt = 0; mMsk = 0; mEdg = 0;
      pinQ = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] prv, cur, hit, clr, wv;
      prv = pinQ[0];
      cur = pinQ[1];
      hit = 0;
      for (int n = 0; n < 32; n++) begin
        if (prv[n] && !cur[n]) hit[n] = 1'b1;
        if (!prv[n] && cur[n] && !mEdg[n]) hit[n] = 1'b1;
      end
      wv  = rev(busWdata);
      clr = 0;
      if (busWe && busAddr[1:0] == 2'b00) begin
        case (busAddr[4:2])
          3'd0: mDir = wv;
          3'd1: mOdr = wv;
          3'd2: mDat = wv;
          3'd3: clr  = wv;
          3'd4: mMsk = wv;
          3'd5: mEdg = wv;
          default: ;
        endcase
      end
      mEvt = (mEvt & ~clr) | hit;
      pinQ.push_back(pinIn);
      void'(pinQ.pop_front());
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] eOe, eOut;
      string rtag;
      for (int n = 0; n < 32; n++) begin
        eOe[n]  = mDir[n] & ~(mOdr[n] & mDat[n]);
        eOut[n] = mDat[n] & ~mOdr[n];
      end
      check("R5", "pinOe", pinOe, eOe);
      check("R5", "pinOut", pinOut, eOut);
      check("R10", "irq", {31'h0, irq}, {31'h0, |(mEvt & mMsk)});
      if (busAddr == 5'h08) rtag = "R4";
      else if (busAddr == 5'h0C) rtag = "R8";
      else rtag = "R2";
      check(rtag, "busRdata", busRdata, expRd(busAddr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    busAddr = a;
    @(negedge clk); #1;
    check(tag, "read", busRdata, exp);
  endtask

  task automatic setPin(input int n, input logic v);
    @(posedge clk); #2;
    pinIn[n] = v;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  initial begin
    #(20 * 20000);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    checks++;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) rdChk("R1", 5'(a * 4), 32'h0);
    check("R1", "pinOe", pinOe, 32'h0);
    check("R1", "irq", {31'h0, irq}, 32'h0);

    // R2 read-back and unmapped offsets
    wr(5'h14, 32'hA5A5_0F0F);
    rdChk("R2", 5'h14, 32'hA5A5_0F0F);
    wr(5'h18, 32'hFFFF_FFFF);
    rdChk("R2", 5'h18, 32'h0);
    wr(5'h11, 32'hFFFF_FFFF);
    rdChk("R2", 5'h10, 32'h0);
    wr(5'h14, 32'h0);

    // R3/R5: pin0 push-pull 1, pin1 open-drain 0, pin2 open-drain 1 (released)
    wr(5'h00, 32'hE000_0000);
    wr(5'h04, 32'h6000_0000);
    wr(5'h08, 32'hA000_0000);
    @(negedge clk);
    check("R3", "pin0 out", {31'h0, pinOut[0]}, 32'h1);
    check("R5", "pin1 oe", {31'h0, pinOe[1]}, 32'h1);
    check("R5", "pin2 oe", {31'h0, pinOe[2]}, 32'h0);
    rdChk("R4", 5'h08, 32'hA000_0000);

    // R4: input level through synchronizer
    setPin(10, 1'b1);
    idle(3);
    rdChk("R4", 5'h08, 32'hA020_0000);

    // R6: both-edge sensing on pin 4
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    setPin(4, 1'b1);
    idle(4);
    rdChk("R6", 5'h0C, 32'h0800_0000);
    check("R6", "irq rise", {31'h0, irq}, 32'h1);
    // R8: zero write keeps, one write clears
    wr(5'h0C, 32'h0);
    rdChk("R8", 5'h0C, 32'h0800_0000);
    wr(5'h0C, 32'h0800_0000);
    rdChk("R8", 5'h0C, 32'h0);
    check("R8", "irq after clear", {31'h0, irq}, 32'h0);
    setPin(4, 1'b0);
    idle(4);
    rdChk("R6", 5'h0C, 32'h0800_0000);
    wr(5'h0C, 32'h0800_0000);

    // R7: falling-only on pin 8
    wr(5'h14, 32'h0080_0000);
    setPin(8, 1'b1);
    idle(4);
    rdChk("R7", 5'h0C, 32'h0);
    setPin(8, 1'b0);
    idle(4);
    rdChk("R7", 5'h0C, 32'h0080_0000);
    wr(5'h0C, 32'h0080_0000);

    // R9: fall on pin 5 lands on the clear write
    setPin(5, 1'b1);
    idle(4);
    rdChk("R9", 5'h0C, 32'h0400_0000);
    setPin(5, 1'b0);
    @(posedge clk);
    wr(5'h0C, 32'h0400_0000);
    rdChk("R9", 5'h0C, 32'h0400_0000);
    wr(5'h0C, 32'h0400_0000);

    // R11: event latched while masked
    wr(5'h10, 32'h0);
    setPin(6, 1'b1);
    idle(4);
    rdChk("R11", 5'h0C, 32'h0200_0000);
    check("R11", "irq masked", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0200_0000);
    @(negedge clk);
    check("R11", "irq unmasked", {31'h0, irq}, 32'h1);

    idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule